// File: doc/BRIEF.md
# Keyboard Edge Interrupt Controller

This block watches a row of key inputs plus one auxiliary input for falling transitions and gathers them into a single sticky interrupt request. Each key input passes through a two-stage synchronizer. A 1-to-0 step between two consecutive synchronized samples counts as a key press. A press sets the shared request latch only when two enables are both set: the global enable and the enable bit that belongs to that input.

Software programs an eight-bit per-key enable mask and a two-bit control word. In the control word, bit 1 is the global enable and bit 0 is a write-one-to-clear strobe for the request latch. The enable for the auxiliary input arrives as a plain input, driven from a bit that lives in another register.

For every key whose mask bit is set, the block forces the effective direction to input and turns on the effective pull-up request. For every other key, the software direction and pull-up settings pass through unchanged. A wake output follows the latch, so that a stopped clock controller can restart the system.

Top module: `kbi_top`

## Requirements
- R1: After reset, the mask readback is 0x00, the global enable reads 0 and the request output `irq` is 0.
- R2: A falling transition sets the latch only if control bit 1 (global enable) is 1 and the enable of that input is 1. A transition on a masked input, or any transition while the global enable is 0, leaves `irq` at 0.
- R3: A key input that goes from 1 to 0 and is first sampled low at rising edge k makes `irq` high after rising edge k+2. Rising transitions and steady levels never set the latch.
- R4: Once set, `irq` stays at 1 until it is cleared, whatever the inputs do.
- R5: A control write with bit 0 set clears `irq` at that edge. A control write with bit 0 clear leaves `irq` unchanged. Readback bit 0 is always 0.
- R6: The auxiliary input `extIn` follows the rules of R2 and R3, with `extEn` as its enable.
- R7: For each key i, `dirEff[i]` is 0 and `pullEff[i]` is 1 when mask bit i is 1. Otherwise `dirEff[i]` equals `portDir[i]` and `pullEff[i]` equals `pullReq[i]`.
- R8: If a press and a clear strobe fall on the same edge, the latch ends up set.
- R9: `wake` is 1 exactly when `irq` is 1.
- R10: A mask write loads `maskWdata` and a control write loads bit 1 into the global enable. Both values read back from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| keyIn | input | NPINS | Key inputs, active low press |
| extIn | input | 1 | Auxiliary input watched for falling transitions |
| extEn | input | 1 | Enable of the auxiliary input |
| portDir | input | NPINS | Software direction, 1 = output |
| pullReq | input | NPINS | Software pull-up request |
| maskWe | input | 1 | Mask register write strobe |
| maskWdata | input | NPINS | Mask write data |
| ctrlWe | input | 1 | Control write strobe |
| ctrlWdata | input | 2 | Bit 1 global enable, bit 0 clear strobe |
| maskRdata | output | NPINS | Mask readback |
| ctrlRdata | output | 2 | Bit 1 global enable, bit 0 reads 0 |
| dirEff | output | NPINS | Effective direction |
| pullEff | output | NPINS | Effective pull-up |
| irq | output | 1 | Latched request |
| wake | output | 1 | Wake request for the clock controller |

## Verification
A detected press and a clear strobe can land on the same clock edge. The bench provokes this by timing the clear write two cycles after a key input is driven low, so that it meets the edge where the press reaches the latch, and it expects the latch to stay set. A reference model compares `irq` on every cycle, and it also runs random phases where clears and presses collide by chance.

// File: rtl/kbi_pkg.sv
package kbi_pkg;
  localparam int CTRL_W      = 2;
  localparam int CTRL_MASTER = 1;
  localparam int CTRL_CLEAR  = 0;

  typedef struct packed {
    logic masterVal;
    logic masterLoad;
    logic maskLoad;
    logic clrLatch;
  } kbiStrobe_t;
endpackage

// File: rtl/kbi_sync.sv
module kbi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic syncOut,
  output logic prevOut
);
  logic [STAGES-1:0] chain;
  logic              prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
      prevQ <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prevQ <= chain[STAGES-1];
    end
  end

  assign syncOut = chain[STAGES-1];
  assign prevOut = prevQ;
endmodule

// File: rtl/kbi_ctrl.sv
module kbi_ctrl
  import kbi_pkg::*;
(
  input  logic              maskWe,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  output kbiStrobe_t        strobe
);
  always_comb begin
    strobe.maskLoad   = maskWe;
    strobe.masterLoad = ctrlWe;
    strobe.masterVal  = ctrlWdata[CTRL_MASTER];
    strobe.clrLatch   = ctrlWe & ctrlWdata[CTRL_CLEAR];
  end
endmodule

// File: rtl/kbi_datapath.sv
module kbi_datapath
  import kbi_pkg::*;
#(
  parameter int NPINS     = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NPINS-1:0] keyIn,
  input  logic             extIn,
  input  logic             extEn,
  input  logic [NPINS-1:0] portDir,
  input  logic [NPINS-1:0] pullReq,
  input  logic [NPINS-1:0] maskWdata,
  input  kbiStrobe_t       strobe,
  output logic [NPINS-1:0] maskQ,
  output logic             masterQ,
  output logic [NPINS-1:0] dirEff,
  output logic [NPINS-1:0] pullEff,
  output logic             irqQ
);
  localparam int NSRC = NPINS + 1;

  logic [NSRC-1:0] srcVec;
  logic [NSRC-1:0] enVec;
  logic [NSRC-1:0] syncVec;
  logic [NSRC-1:0] prevVec;
  logic [NSRC-1:0] fallVec;
  logic            pressHit;

  assign srcVec = {extIn, keyIn};
  assign enVec  = {extEn, maskQ};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    kbi_sync #(.STAGES(SYNC_DEPTH)) u_sync (
      .clk    (clk),
      .rstN   (rstN),
      .din    (srcVec[i]),
      .syncOut(syncVec[i]),
      .prevOut(prevVec[i])
    );
    assign fallVec[i] = prevVec[i] & ~syncVec[i];
  end

  assign pressHit = masterQ & (|(fallVec & enVec));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ   <= '0;
      masterQ <= 1'b0;
      irqQ    <= 1'b0;
    end else begin
      if (strobe.maskLoad)   maskQ   <= maskWdata;
      if (strobe.masterLoad) masterQ <= strobe.masterVal;
      if (pressHit)             irqQ <= 1'b1;
      else if (strobe.clrLatch) irqQ <= 1'b0;
    end
  end

  assign dirEff  = portDir & ~maskQ;
  assign pullEff = pullReq | maskQ;
endmodule

// File: rtl/kbi_top.sv
module kbi_top
  import kbi_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NPINS-1:0]  keyIn,
  input  logic              extIn,
  input  logic              extEn,
  input  logic [NPINS-1:0]  portDir,
  input  logic [NPINS-1:0]  pullReq,
  input  logic              maskWe,
  input  logic [NPINS-1:0]  maskWdata,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  output logic [NPINS-1:0]  maskRdata,
  output logic [CTRL_W-1:0] ctrlRdata,
  output logic [NPINS-1:0]  dirEff,
  output logic [NPINS-1:0]  pullEff,
  output logic              irq,
  output logic              wake
);
  kbiStrobe_t strobe;
  logic       masterQ;

  kbi_ctrl u_ctrl (
    .maskWe   (maskWe),
    .ctrlWe   (ctrlWe),
    .ctrlWdata(ctrlWdata),
    .strobe   (strobe)
  );

  kbi_datapath #(.NPINS(NPINS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .keyIn    (keyIn),
    .extIn    (extIn),
    .extEn    (extEn),
    .portDir  (portDir),
    .pullReq  (pullReq),
    .maskWdata(maskWdata),
    .strobe   (strobe),
    .maskQ    (maskRdata),
    .masterQ  (masterQ),
    .dirEff   (dirEff),
    .pullEff  (pullEff),
    .irqQ     (irq)
  );

  always_comb begin
    ctrlRdata              = '0;
    ctrlRdata[CTRL_MASTER] = masterQ;
  end

  assign wake = irq;
endmodule

// File: rtl/kbi_chk.sv
module kbi_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             extEn,
  input logic             ctrlWe,
  input logic [1:0]       ctrlWdata,
  input logic [NPINS-1:0] maskRdata,
  input logic [1:0]       ctrlRdata,
  input logic [NPINS-1:0] dirEff,
  input logic [NPINS-1:0] pullEff,
  input logic             irq,
  input logic             wake
);
  a_r2_no_set_when_master_off: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlRdata[1] && !irq) |=> !irq);

  a_r2_no_set_when_all_masked: assert property (@(posedge clk) disable iff (!rstN)
    (maskRdata == '0 && !extEn && !irq) |=> !irq);

  a_r4_latch_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(ctrlWe && ctrlWdata[0])) |=> irq);

  a_r5_clear_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdata[0] == 1'b0);

  a_r7_enabled_pin_is_input: assert property (@(posedge clk) disable iff (!rstN)
    (maskRdata & dirEff) == '0);

  a_r7_enabled_pin_pulled: assert property (@(posedge clk) disable iff (!rstN)
    (maskRdata & ~pullEff) == '0);

  a_r9_wake_follows_irq: assert property (@(posedge clk) disable iff (!rstN)
    wake == irq);

  a_r10_master_write: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWe |=> ctrlRdata[1] == $past(ctrlWdata[1]));
endmodule

bind kbi_top kbi_chk #(.NPINS(NPINS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .extEn    (extEn),
  .ctrlWe   (ctrlWe),
  .ctrlWdata(ctrlWdata),
  .maskRdata(maskRdata),
  .ctrlRdata(ctrlRdata),
  .dirEff   (dirEff),
  .pullEff  (pullEff),
  .irq      (irq),
  .wake     (wake)
);

// File: tb/sim_kbi_top.sv
module sim_kbi_top;
  localparam int PERIOD = 10;
  localparam int NPINS  = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [NPINS-1:0] keyIn = '1;
  logic             extIn = 1'b1;
  logic             extEn = 1'b0;
  logic [NPINS-1:0] portDir = '0;
  logic [NPINS-1:0] pullReq = '0;
  logic             maskWe = 1'b0;
  logic [NPINS-1:0] maskWdata = '0;
  logic             ctrlWe = 1'b0;
  logic [1:0]       ctrlWdata = '0;
  logic [NPINS-1:0] maskRdata;
  logic [1:0]       ctrlRdata;
  logic [NPINS-1:0] dirEff;
  logic [NPINS-1:0] pullEff;
  logic             irq;
  logic             wake;

  kbi_top #(.NPINS(NPINS)) u0 (
    .clk(clk), .rstN(rstN), .keyIn(keyIn), .extIn(extIn), .extEn(extEn),
    .portDir(portDir), .pullReq(pullReq), .maskWe(maskWe), .maskWdata(maskWdata),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .maskRdata(maskRdata),
    .ctrlRdata(ctrlRdata), .dirEff(dirEff), .pullEff(pullEff), .irq(irq), .wake(wake)
  );

  always #(PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string tag    = "R1";

  // behavioural reference
  bit [NPINS:0]   hist[$];
  bit [NPINS-1:0] mMask;
  bit             mMaster;
  bit             mIrq;

  always @(posedge clk) begin
    if (!rstN) begin
      mMask = '0; mMaster = 1'b0; mIrq = 1'b0;
      hist = '{'0, '0, '0};
    end else begin
      bit [NPINS:0] fallV;
      bit [NPINS:0] enV;
      bit           hit;
      fallV = hist[2] & ~hist[1];
      enV   = {extEn, mMask};
      hit   = mMaster && ((fallV & enV) != 0);
      if (hit) mIrq = 1'b1;
      else if (ctrlWe && ctrlWdata[0]) mIrq = 1'b0;
      if (maskWe) mMask = maskWdata;
      if (ctrlWe) mMaster = ctrlWdata[1];
      hist.push_front({extIn, keyIn});
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (rstN) begin
      chk(tag,    32'(irq),       32'(mIrq),              "irq");
      chk("R9",   32'(wake),      32'(mIrq),              "wake");
      chk("R10",  32'(maskRdata), 32'(mMask),             "mask readback");
      chk("R10",  32'(ctrlRdata), 32'({mMaster, 1'b0}),   "ctrl readback");
      chk("R7",   32'(dirEff),    32'(portDir & ~mMask),  "dirEff");
      chk("R7",   32'(pullEff),   32'(pullReq | mMask),   "pullEff");
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic writeMask(input logic [NPINS-1:0] v);
    maskWe = 1'b1; maskWdata = v; tick(); maskWe = 1'b0;
  endtask

  task automatic writeCtrl(input logic [1:0] v);
    ctrlWe = 1'b1; ctrlWdata = v; tick(); ctrlWe = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(PERIOD * 50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    ticks(3);
    @(negedge clk);
    rstN = 1'b1;
    tick();
    tag = "R1";
    chk("R1", 32'(irq), 0, "irq after reset");
    chk("R1", 32'(maskRdata), 0, "mask after reset");
    chk("R1", 32'(ctrlRdata), 0, "ctrl after reset");
    ticks(3);

    // R2: all masks set but global enable off
    tag = "R2";
    writeMask('1);
    keyIn[2] = 1'b0; ticks(5);
    chk("R2", 32'(irq), 0, "press with global enable off");
    keyIn[2] = 1'b1; ticks(3);

    // R2: enabled globally, only key 2 unmasked, press key 5
    writeMask(8'h04);
    writeCtrl(2'b10);
    keyIn[5] = 1'b0; ticks(5);
    chk("R2", 32'(irq), 0, "press on masked key");
    keyIn[5] = 1'b1; ticks(3);

    // R3: latency of an enabled press
    tag = "R3";
    keyIn[2] = 1'b0;
    tick(); tick();
    chk("R3", 32'(irq), 0, "irq before third edge");
    tick();
    chk("R3", 32'(irq), 1, "irq after third edge");

    // R4: stays set through release and other activity
    tag = "R4";
    keyIn[2] = 1'b1; ticks(4);
    keyIn = 8'h00; ticks(2); keyIn = '1; ticks(3);
    chk("R4", 32'(irq), 1, "latch sticky");

    // R5: write without clear bit, then with clear bit
    tag = "R5";
    writeCtrl(2'b10);
    chk("R5", 32'(irq), 1, "write with bit0=0 keeps irq");
    writeCtrl(2'b11);
    chk("R5", 32'(irq), 0, "write with bit0=1 clears irq");
    chk("R5", 32'(ctrlRdata[0]), 0, "clear bit reads zero");
    ticks(2);

    // R3: rising edges and levels only
    tag = "R3";
    keyIn[2] = 1'b0;
    writeCtrl(2'b11); ticks(4);
    writeCtrl(2'b11);
    keyIn[2] = 1'b1; ticks(6);
    chk("R3", 32'(irq), 0, "rising edge does not set");

    // R6: auxiliary input
    tag = "R6";
    extEn = 1'b0; extIn = 1'b0; ticks(5);
    chk("R6", 32'(irq), 0, "aux press while disabled");
    extIn = 1'b1; ticks(3);
    extEn = 1'b1; extIn = 1'b0; ticks(4);
    chk("R6", 32'(irq), 1, "aux press while enabled");
    extIn = 1'b1; ticks(3);

    // R8: press arrives at the latch on the same edge as a clear strobe
    tag = "R8";
    keyIn[2] = 1'b0;
    tick(); tick();
    ctrlWe = 1'b1; ctrlWdata = 2'b11;
    tick();
    ctrlWe = 1'b0;
    chk("R8", 32'(irq), 1, "set beats clear");
    keyIn[2] = 1'b1;
    writeCtrl(2'b11);
    chk("R8", 32'(irq), 0, "clear afterwards");

    // R7: direction and pull-up overrides
    tag = "R7";
    for (int k = 0; k < 12; k++) begin
      portDir = NPINS'($urandom);
      pullReq = NPINS'($urandom);
      writeMask(NPINS'($urandom));
      tick();
    end

    // random mix, colliding presses and clears
    tag = "R3";
    writeCtrl(2'b10);
    for (int k = 0; k < 400; k++) begin
      keyIn = NPINS'($urandom | $urandom);
      extIn = 1'($urandom);
      extEn = 1'($urandom);
      portDir = NPINS'($urandom);
      pullReq = NPINS'($urandom);
      maskWe = ($urandom % 8) == 0;
      maskWdata = NPINS'($urandom);
      ctrlWe = ($urandom % 4) == 0;
      ctrlWdata = {($urandom % 6) != 0, 1'($urandom)};
      tick();
    end
    maskWe = 1'b0; ctrlWe = 1'b0;
    ticks(4);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule